// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave serial control port in front of a small bank of configuration and profile registers. A host opens a transfer by pulling chip select low. It then clocks in one instruction byte that holds a read/write flag and a register address. After that come the data bytes of the addressed register. The number of data bytes is fixed for each address. Input bits are taken on the rising edge of the serial clock and read bits are launched on its falling edge. The port works in the system clock domain. It samples the serial pins through a synchronizer and detects their edges there.

Register 0 is the port's own control register. One of its bits selects the three-wire or two-wire arrangement. In three-wire mode read data leaves on a dedicated output. In two-wire mode read data leaves on the shared data line, with an output enable. Another bit selects MSB-first or LSB-first order. Both settings are captured when chip select falls, so a change applies from the next transfer. Every completed register write raises a one-cycle strobe toward the core, carrying the address and the zero-extended value.

The state machine has five states: IDLE (chip select high), INSTR (collecting the instruction byte), WDATA (collecting write data), RDATA (shifting out read data) and SKIP (ignoring the remaining serial clocks). Transitions: IDLE to INSTR when chip select is low; INSTR to WDATA or RDATA after the eighth bit if the address has a width; INSTR to SKIP after the eighth bit for an unmapped address; WDATA to SKIP after the last data bit, committing the write; RDATA to SKIP after the last data bit; any state to IDLE when chip select is high.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset all registers read as zero, the port is in two-wire MSB-first mode, and `sdo`, `sdio_o`, `sdio_oe` and `wr_en` are 0.
- R2: Bits on `sdio_i` are taken on rising `sclk` edges. The first eight bits of a transfer form the instruction byte. Its bit 7 set to 1 means read and its bits [4:0] give the address. In MSB-first mode the first bit received is bit 7; in LSB-first mode it is bit 0.
- R3: The data length per address is: 0 → 4 bytes, 1 → 5 bytes, 2 to 5 → 2 bytes, 6 to 13 → 8 bytes. Addresses 14 to 31 have no data bytes.
- R4: A write stores exactly as many bits as the address's length. One system clock after the last bit, `wr_en` pulses for one cycle with `wr_addr` and with `wr_data` zero-extended to 64 bits, and the register takes that value. In MSB-first mode the first data bit is the register's top bit (8·bytes−1); in LSB-first mode it is bit 0.
- R5: A read returns the register's value, using the same bit order as R4. Each read bit is launched after a falling `sclk` edge, so the host samples it on the next rising edge.
- R6: When register 0 bit 14 is 1 (three-wire mode), read data appears on `sdo` and `sdio_oe` stays 0. When that bit is 0 (two-wire mode), read data appears on `sdio_o` with `sdio_oe` = 1, and `sdo` stays 0.
- R7: Serial clocks after the last data bit are ignored until chip select goes high. They cause no further write and leave the register unchanged.
- R8: Chip select going high at any point ends the transfer. A partly received write is not committed, and the next transfer starts with a new instruction byte.
- R9: When register 0 bit 15 is 1, transfers are LSB first; when it is 0 they are MSB first. The order and mode bits are taken when chip select falls, so a change applies from the next transfer.
- R10: A transfer to an unmapped address writes nothing and drives no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data into the port (shared line in two-wire mode) |
| sdo | output | 1 | Read data in three-wire mode |
| sdio_o | output | 1 | Read data onto the shared line in two-wire mode |
| sdio_oe | output | 1 | Output enable for the shared line |
| wr_en | output | 1 | One-cycle register write strobe to the core |
| wr_addr | output | 5 | Address of the written register |
| wr_data | output | 64 | Written value, zero-extended |

## Verification
Two events can land in the same transfer window and interact. The first is a write to register 0 that changes the mode or bit order. The second is the transfer that follows it, which must already use the new setting, while the write itself must finish under the old one. The bench provokes this by writing the three-wire bit in MSB order, then reading back in three-wire mode. It then writes the LSB-first bit in MSB order and immediately runs LSB-first writes and reads. Results are judged by comparing read-back values, and the data-line choice, against arithmetic patterns. A second collision is chip select rising in mid-word while a write is being collected. The bench checks that the strobe count and the stored value stay unchanged.

// File: rtl/scp_pkg.sv
package scp_pkg;
    localparam int ADDR_W        = 5;
    localparam int CFG_ORDER_BIT = 15;
    localparam int CFG_3WIRE_BIT = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INSTR,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } scp_state_e;

    // Data byte count for each address; zero marks an unmapped address.
    function automatic logic [3:0] reg_bytes(input logic [ADDR_W-1:0] a);
        if (a == 5'd0)       return 4'd4;
        else if (a == 5'd1)  return 4'd5;
        else if (a <= 5'd5)  return 4'd2;
        else if (a <= 5'd13) return 4'd8;
        else                 return 4'd0;
    endfunction
endpackage

// File: rtl/scp_pinsync.sv
module scp_pinsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic din,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_hi,
    output logic dbit
);
    // stage bits: [2] sclk, [1] cs_n, [0] data
    logic [2:0] stg [STAGES];
    logic       sclk_p;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= 3'b010;
            sclk_p <= 1'b0;
        end else begin
            stg[0] <= {sclk, cs_n, din};
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            sclk_p <= stg[STAGES-1][2];
        end
    end

    assign sclk_rise = stg[STAGES-1][2] & ~sclk_p;
    assign sclk_fall = ~stg[STAGES-1][2] & sclk_p;
    assign cs_hi     = stg[STAGES-1][1];
    assign dbit      = stg[STAGES-1][0];
endmodule

// File: rtl/scp_bank.sv
module scp_bank
    import scp_pkg::*;
#(
    parameter int NUM_REGS = 14,
    parameter int DATA_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              cfg_lsb,
    output logic              cfg_3w
);
    localparam int IW = $clog2(NUM_REGS);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)                               q <= '0;
            else if (we && waddr == ADDR_W'(g))       q <= wdata;
        end
        assign regs[g] = q;
    end

    always_comb begin
        if (32'(raddr) < NUM_REGS) rdata = regs[raddr[IW-1:0]];
        else                       rdata = '0;
    end

    assign cfg_lsb = regs[0][CFG_ORDER_BIT];
    assign cfg_3w  = regs[0][CFG_3WIRE_BIT];

    // R9: port settings move only through a committed write
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(cfg_lsb) && $stable(cfg_3w)));
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import scp_pkg::*;
#(
    parameter int NUM_REGS    = 14,
    parameter int MAX_BYTES   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk,
    input  logic                   cs_n,
    input  logic                   sdio_i,
    output logic                   sdo,
    output logic                   sdio_o,
    output logic                   sdio_oe,
    output logic                   wr_en,
    output logic [4:0]             wr_addr,
    output logic [MAX_BYTES*8-1:0] wr_data
);
    localparam int DATA_W = MAX_BYTES * 8;
    localparam int NB_W   = $clog2(DATA_W + 1);
    localparam int IDX_W  = $clog2(DATA_W);

    logic rise, fall, cs_hi, dbit;
    scp_pinsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(sdio_i),
        .sclk_rise(rise), .sclk_fall(fall), .cs_hi(cs_hi), .dbit(dbit)
    );

    scp_state_e        st;
    logic [NB_W-1:0]   cnt_q, nbits_q, nbits_n, didx;
    logic [7:0]        instr_q, instr_next;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic [DATA_W-1:0] acc_q, acc_next, shadow_q, bank_rdata;
    logic [3:0]        bytes_n;
    logic [2:0]        ibit;
    logic              lsb_q, w3_q, commit, cfg_lsb, cfg_3w;
    logic              unused_bits;

    scp_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(commit), .waddr(addr_q), .wdata(acc_next),
        .raddr(addr_n), .rdata(bank_rdata), .cfg_lsb(cfg_lsb), .cfg_3w(cfg_3w)
    );

    always_comb begin
        ibit       = lsb_q ? cnt_q[2:0] : 3'd7 - cnt_q[2:0];
        instr_next = instr_q;
        instr_next[ibit] = dbit;
        addr_n     = instr_next[4:0];
        bytes_n    = (32'(addr_n) < NUM_REGS) ? reg_bytes(addr_n) : 4'd0;
        nbits_n    = NB_W'({bytes_n, 3'b000});
        didx       = lsb_q ? cnt_q : nbits_q - NB_W'(1) - cnt_q;
        acc_next   = acc_q;
        acc_next[didx[IDX_W-1:0]] = dbit;
        commit     = (st == ST_WDATA) && rise && !cs_hi && (cnt_q == nbits_q - NB_W'(1));
    end
    assign unused_bits = ^{instr_next[6:5], didx[NB_W-1]};

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; cnt_q <= '0; nbits_q <= '0; instr_q <= '0;
            addr_q <= '0; acc_q <= '0; shadow_q <= '0; lsb_q <= 1'b0; w3_q <= 1'b0;
        end else if (cs_hi) begin
            st <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    st <= ST_INSTR; cnt_q <= '0; instr_q <= '0; acc_q <= '0;
                    lsb_q <= cfg_lsb; w3_q <= cfg_3w;
                end
                ST_INSTR: if (rise) begin
                    instr_q <= instr_next;
                    if (cnt_q == NB_W'(7)) begin
                        cnt_q   <= '0;
                        addr_q  <= addr_n;
                        nbits_q <= nbits_n;
                        shadow_q <= bank_rdata;
                        if (nbits_n == '0)      st <= ST_SKIP;
                        else if (instr_next[7]) st <= ST_RDATA;
                        else                    st <= ST_WDATA;
                    end else cnt_q <= cnt_q + NB_W'(1);
                end
                ST_WDATA: if (rise) begin
                    acc_q <= acc_next;
                    if (cnt_q == nbits_q - NB_W'(1)) st <= ST_SKIP;
                    else cnt_q <= cnt_q + NB_W'(1);
                end
                ST_RDATA: if (rise) begin
                    if (cnt_q == nbits_q - NB_W'(1)) st <= ST_SKIP;
                    else cnt_q <= cnt_q + NB_W'(1);
                end
                ST_SKIP: st <= ST_SKIP;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo <= 1'b0; sdio_o <= 1'b0; sdio_oe <= 1'b0;
            wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
        end else begin
            wr_en <= commit;
            if (commit) begin
                wr_addr <= addr_q;
                wr_data <= acc_next;
            end
            if (cs_hi || st == ST_IDLE) begin
                sdo <= 1'b0; sdio_o <= 1'b0; sdio_oe <= 1'b0;
            end else if (fall) begin
                if (st == ST_RDATA && w3_q) begin
                    sdo <= shadow_q[didx[IDX_W-1:0]]; sdio_o <= 1'b0; sdio_oe <= 1'b0;
                end else if (st == ST_RDATA) begin
                    sdo <= 1'b0; sdio_o <= shadow_q[didx[IDX_W-1:0]]; sdio_oe <= 1'b1;
                end else begin
                    sdo <= 1'b0; sdio_o <= 1'b0; sdio_oe <= 1'b0;
                end
            end
        end
    end

    // R8: chip select high always returns to IDLE
    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> (st == ST_IDLE));
    // R4: a strobe follows only the last bit of a write word
    assert_wr_full_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st == ST_SKIP || st == ST_IDLE) && $past(st) == ST_WDATA);
    // R6: shared line driven only in two-wire mode
    assert_oe_two_wire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> (!w3_q && st != ST_IDLE));
    // R6: dedicated output quiet in two-wire mode
    assert_sdo_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !w3_q |-> !sdo);
    // R10: no strobe for an unmapped address
    assert_no_unmapped_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_addr) < NUM_REGS));
    // R5: read bits move only after a falling serial clock
    assert_fall_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && $past(st) != ST_IDLE && !$stable(sdo)) |-> $past(fall));
    // R3: bit counter stays inside the word length
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WDATA || st == ST_RDATA) |-> (cnt_q < nbits_q));
endmodule

// File: tb/sim_serial_cfg_port.sv
module sim_serial_cfg_port;
    localparam int CLK_P  = 10;
    localparam int HALF_T = CLK_P * 6;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdio_i = 1'b0;
    logic sdo, sdio_o, sdio_oe, wr_en;
    logic [4:0]  wr_addr;
    logic [63:0] wr_data;

    int checks = 0, errors = 0, wr_cnt = 0;
    logic [4:0]  last_addr;
    logic [63:0] last_data;
    logic mode3 = 1'b0, lsb = 1'b0, oe_seen, sdo_seen;
    logic [63:0] rv;

    serial_cfg_port u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_i(sdio_i),
        .sdo(sdo), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data));

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) if (wr_en) begin
        wr_cnt++; last_addr = wr_addr; last_data = wr_data;
    end

    function automatic int nbytes(int a);
        if (a == 0) return 4;
        if (a == 1) return 5;
        if (a <= 5) return 2;
        if (a <= 13) return 8;
        return 0;
    endfunction

    function automatic logic [63:0] wmask(int a);
        if (nbytes(a) == 8) return '1;
        return (64'd1 << (8 * nbytes(a))) - 64'd1;
    endfunction

    function automatic logic [63:0] pat(int a, int salt);
        return (64'h9E3779B97F4A7C15 * 64'(a + salt)) ^ {8{8'(a * 29 + salt)}};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bit_io(input logic b, output logic r);
        sdio_i = b;
        #HALF_T;
        r = mode3 ? sdo : sdio_o;
        if (sdio_oe) oe_seen = 1'b1;
        if (sdo) sdo_seen = 1'b1;
        sclk = 1'b1;
        #HALF_T;
        sclk = 1'b0;
    endtask

    task automatic open_cycle(input logic rd, input int a);
        logic [7:0] ib;
        logic r;
        ib = {rd, 2'b00, 5'(a)};
        oe_seen = 1'b0; sdo_seen = 1'b0;
        cs_n = 1'b0;
        #HALF_T;
        for (int i = 0; i < 8; i++) bit_io(lsb ? ib[i] : ib[7 - i], r);
    endtask

    task automatic close_cycle();
        #HALF_T;
        cs_n = 1'b1; sdio_i = 1'b0;
        #(HALF_T * 2);
    endtask

    task automatic do_write(input int a, input logic [63:0] d, input int nsend);
        int nb;
        logic r;
        nb = nbytes(a) * 8;
        open_cycle(1'b0, a);
        for (int k = 0; k < nsend; k++)
            bit_io((k >= nb) ? 1'b1 : (lsb ? d[k] : d[nb - 1 - k]), r);
        close_cycle();
    endtask

    task automatic do_read(input int a, output logic [63:0] v);
        int nb;
        logic r;
        nb = nbytes(a) * 8;
        v = '0;
        open_cycle(1'b1, a);
        for (int k = 0; k < (nb == 0 ? 16 : nb); k++) begin
            bit_io(1'b0, r);
            if (k < nb) v[lsb ? k : nb - 1 - k] = r;
        end
        close_cycle();
    endtask

    initial begin
        #(CLK_P * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c0;
        logic [63:0] e;
        #(CLK_P * 4 + CLK_P / 2);
        rst_n = 1'b1;
        #(CLK_P * 4);
        // R1 reset state
        chk(sdo == 0 && sdio_o == 0 && sdio_oe == 0 && wr_en == 0, "R1 outputs after reset",
            {60'd0, sdo, sdio_o, sdio_oe, wr_en}, 64'd0);
        do_read(6, rv);
        chk(rv == 0, "R1 register reads zero", rv, 64'd0);

        // R2 R3 R4 sweep of every mapped address except the control register
        for (int a = 1; a < 14; a++) begin
            c0 = wr_cnt;
            e = pat(a, 3) & wmask(a);
            do_write(a, pat(a, 3), nbytes(a) * 8);
            chk(wr_cnt == c0 + 1 && last_addr == 5'(a) && last_data == e,
                $sformatf("R4 strobe addr %0d", a), last_data, e);
        end
        for (int a = 1; a < 14; a++) begin
            e = pat(a, 3) & wmask(a);
            do_read(a, rv);
            chk(rv == e, $sformatf("R2/R3/R5 readback addr %0d", a), rv, e);
            chk(oe_seen && !sdo_seen, $sformatf("R6 two-wire line use addr %0d", a),
                {62'd0, oe_seen, sdo_seen}, 64'd2);
        end

        // R10 unmapped address
        c0 = wr_cnt;
        do_write(20, 64'hFFFF, 16);
        chk(wr_cnt == c0, "R10 no strobe for unmapped write", 64'(wr_cnt - c0), 64'd0);
        do_read(20, rv);
        chk(!oe_seen && !sdo_seen, "R10 no drive for unmapped read", {62'd0, oe_seen, sdo_seen}, 64'd0);

        // R7 surplus bits ignored
        c0 = wr_cnt;
        do_write(3, 64'h0000_0000_0000_5AC3, 32);
        chk(wr_cnt == c0 + 1, "R7 single strobe with surplus bits", 64'(wr_cnt - c0), 64'd1);
        do_read(3, rv);
        chk(rv == 64'h5AC3, "R7 surplus bits leave register", rv, 64'h5AC3);

        // R8 abort mid-word
        c0 = wr_cnt;
        e = pat(7, 3);
        do_write(7, 64'h1234_5678_9ABC_DEF0, 30);
        chk(wr_cnt == c0, "R8 no strobe after abort", 64'(wr_cnt - c0), 64'd0);
        do_read(7, rv);
        chk(rv == e, "R8 aborted write not committed", rv, e);

        // R6 switch to three-wire mode; R9 takes effect next cycle
        do_write(0, 64'h4000, 32);
        mode3 = 1'b1;
        do_read(6, rv);
        e = pat(6, 3);
        chk(rv == e, "R6 three-wire read value", rv, e);
        chk(!oe_seen, "R6 shared line idle in three-wire", {63'd0, oe_seen}, 64'd0);
        do_read(0, rv);
        chk(rv == 64'h4000, "R6 control register value", rv, 64'h4000);

        // R9 switch to LSB first
        do_write(0, 64'hC000, 32);
        lsb = 1'b1;
        c0 = wr_cnt;
        do_write(9, pat(9, 11), 64);
        chk(wr_cnt == c0 + 1 && last_data == pat(9, 11), "R9 LSB-first write", last_data, pat(9, 11));
        do_write(1, pat(1, 11), 40);
        chk(last_data == (pat(1, 11) & wmask(1)), "R9 LSB-first 5-byte write", last_data, pat(1, 11) & wmask(1));
        do_read(9, rv);
        chk(rv == pat(9, 11), "R9 LSB-first read", rv, pat(9, 11));
        do_read(1, rv);
        chk(rv == (pat(1, 11) & wmask(1)), "R9 LSB-first 5-byte read", rv, pat(1, 11) & wmask(1));

        // R9 back to MSB two-wire, written in LSB order
        do_write(0, 64'h0, 32);
        lsb = 1'b0; mode3 = 1'b0;
        do_read(9, rv);
        chk(rv == pat(9, 11), "R9 MSB-first after return", rv, pat(9, 11));
        chk(oe_seen, "R6 two-wire restored", {63'd0, oe_seen}, 64'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule